// File: doc/BRIEF.md
# Two-Phase Mailbox Doorbell

This block is a device-side doorbell register through which a host posts one command whose mailbox address is too wide for a single 32-bit register write. The host makes two writes. The first write carries the upper part of the address and has the phase flag set. The second write carries the lower part and has the phase flag clear. The block joins the two halves into a 64-bit, 16-byte-aligned mailbox address. It then hands that address to a downstream command engine with a one-cycle issue strobe.

A single readable ready flag tells the host where the sequence stands. After the upper write, ready drops and then returns after a fixed delay to acknowledge that half. After the lower write, ready stays low until the command engine reports it has finished. When that happens, the block strobes a completion-entry write into the mailbox, and ready rises on the next cycle. Writes that break the sequence are dropped and set a sticky protocol-error flag.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, ready reads 1, the half-held flag and the error flag read 0, and neither `issueValid` nor `complWrite` is asserted.
- R2: A write with bit 1 = 1, accepted while the block is idle, stores `wrData[31:2]` as address bits [63:34]. Ready reads 0 until exactly `ACK_DELAY` clock edges after the accepting edge, and then reads 1. The half-held flag reads 1 from the accepting edge until the low half is accepted.
- R3: A write with bit 1 = 0, made after the high half has been acknowledged, raises `issueValid` in the cycle after the write. At that point `issueAddr` = {stored high half, `wrData[31:2]`, 4'b0000}.
- R4: From the accepted low write until completion, ready reads 0. An `engineDone` pulse sampled while a command is outstanding produces a one-cycle `complWrite` in the next cycle, and ready reads 1 in the cycle after that.
- R5: A low write made when no acknowledged high half is held (idle, or while the high-phase acknowledge is still pending) is ignored and sets the error flag.
- R6: A high write made at any point from an accepted high write until completion is ignored and sets the error flag. The stored high half and the acknowledge timing are unaffected.
- R7: The read word is {29'b0, error, half-held, ready} at bits [2], [1], [0]. The error flag stays set until reset.
- R8: An `engineDone` pulse while no command is outstanding has no effect: `complWrite` stays 0 and ready is unchanged.
- R9: `issueValid` lasts exactly one cycle, and `issueAddr` keeps its value until the next accepted low write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write word; bit 1 = phase flag, bits [31:2] = address field |
| rdData | output | 32 | Read word: ready, half-held, error |
| issueValid | output | 1 | One-cycle command-issue strobe |
| issueAddr | output | 64 | Assembled mailbox address |
| engineDone | input | 1 | Command engine finished |
| complWrite | output | 1 | Strobe to write the completion entry |

## Verification
The bench builds the block with `ACK_DELAY` = 3. This keeps the acknowledge window short enough to probe every cycle of it, including a disallowed write placed inside it. Address halves are produced by an arithmetic sweep, so that each address bit takes both values, and the expected address is computed by concatenation. Each misuse case (low write while idle, low write before the acknowledge, high write while a command is open) and each stray completion pulse is followed by a sequence that must still run normally.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_W       = 32;
  localparam int FIELD_W     = 30;
  localparam int ALIGN_W     = 4;
  localparam int MBOX_ADDR_W = 2 * FIELD_W + ALIGN_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_WAIT,
    ST_HI_ACKED,
    ST_BUSY,
    ST_COMPL
  } mbState_e;

  typedef struct packed {
    logic latchHi;
    logic issueLo;
  } mbStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ACK_DELAY = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrHi,
  input  logic      engineDone,
  output mbStrobe_t strobe,
  output logic      ready,
  output logic      hiHeld,
  output logic      protoErr,
  output logic      complWrite
);
  localparam int CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DELAY - 1);

  mbState_e state, stateNext;
  logic [CNT_W-1:0] ackCnt;
  logic hiWrite, loWrite, acceptHi, acceptLo, badWrite;

  assign hiWrite  = wrEn & wrHi;
  assign loWrite  = wrEn & ~wrHi;
  assign acceptHi = hiWrite & (state == ST_IDLE);
  assign acceptLo = loWrite & (state == ST_HI_ACKED);
  assign badWrite = (hiWrite & ~acceptHi) | (loWrite & ~acceptLo);

  assign strobe.latchHi = acceptHi;
  assign strobe.issueLo = acceptLo;

  assign ready  = (state == ST_IDLE) || (state == ST_HI_ACKED);
  assign hiHeld = (state == ST_HI_WAIT) || (state == ST_HI_ACKED);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (acceptHi) stateNext = ST_HI_WAIT;
      ST_HI_WAIT:  if (ackCnt == '0) stateNext = ST_HI_ACKED;
      ST_HI_ACKED: if (acceptLo) stateNext = ST_BUSY;
      ST_BUSY:     if (engineDone) stateNext = ST_COMPL;
      ST_COMPL:    stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      ackCnt     <= '0;
      protoErr   <= 1'b0;
      complWrite <= 1'b0;
    end else begin
      state      <= stateNext;
      complWrite <= (state == ST_BUSY) && engineDone;
      if (acceptHi) ackCnt <= CNT_LOAD;
      else if (state == ST_HI_WAIT && ackCnt != '0) ackCnt <= ackCnt - 1'b1;
      if (badWrite) protoErr <= 1'b1;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R4
  compl_then_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    complWrite |=> ready);

  // R4
  ready_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ready) && !hiHeld) |-> $past(complWrite));

  // R8
  single_compl_chk: assert property (@(posedge clk) disable iff (!rstN)
    complWrite |=> !complWrite);
endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  mbStrobe_t              strobe,
  input  logic [FIELD_W-1:0]     wrField,
  output logic                   issueValid,
  output logic [MBOX_ADDR_W-1:0] issueAddr
);
  logic [FIELD_W-1:0] hiHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiHalf     <= '0;
      issueValid <= 1'b0;
      issueAddr  <= '0;
    end else begin
      issueValid <= strobe.issueLo;
      if (strobe.latchHi) hiHalf <= wrField;
      if (strobe.issueLo) issueAddr <= {hiHalf, wrField, {ALIGN_W{1'b0}}};
    end
  end

  // R9
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.issueLo |=> $stable(issueAddr));

  // R3
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueAddr[ALIGN_W-1:0] == '0));
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int ACK_DELAY = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        issueValid,
  output logic [63:0] issueAddr,
  input  logic        engineDone,
  output logic        complWrite
);
  mbStrobe_t strobe;
  logic ready, hiHeld, protoErr;

  mbox_ctrl #(.ACK_DELAY(ACK_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrHi(wrData[1]),
    .engineDone(engineDone), .strobe(strobe), .ready(ready),
    .hiHeld(hiHeld), .protoErr(protoErr), .complWrite(complWrite)
  );

  mbox_data i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrField(wrData[31:2]),
    .issueValid(issueValid), .issueAddr(issueAddr)
  );

  assign rdData = {{(REG_W-3){1'b0}}, protoErr, hiHeld, ready};

  // R4
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !rdData[0]);
endmodule

// File: tb/test_mbox_doorbell.sv
module test_mbox_doorbell;
  localparam int ACKD = 3;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, engineDone = 1'b0;
  logic [31:0] wrData = '0, rdData;
  logic issueValid, complWrite;
  logic [63:0] issueAddr;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  mbox_doorbell #(.ACK_DELAY(ACKD)) i_mbox_doorbell (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .issueValid(issueValid), .issueAddr(issueAddr),
    .engineDone(engineDone), .complWrite(complWrite)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic regWrite(input logic hi, input logic [29:0] field);
    @(negedge clk) begin wrEn = 1'b1; wrData = {field, hi, 1'b0}; end
    @(negedge clk) begin wrEn = 1'b0; wrData = '0; end
  endtask

  task automatic pulseDone();
    @(negedge clk) engineDone = 1'b1;
    @(negedge clk) engineDone = 1'b0;
  endtask

  // high write, then watch acknowledge window cycle by cycle
  task automatic hiPhase(input logic [29:0] hiF);
    regWrite(1'b1, hiF);
    chk(rdData[1:0] == 2'b10, "R2 hold", 64'(rdData), 64'h2);
    for (int k = 1; k < ACKD; k++) begin
      @(negedge clk);
      chk(rdData[0] == 1'b0, "R2 wait", 64'(rdData[0]), 64'h0);
    end
    @(negedge clk);
    chk(rdData[1:0] == 2'b11, "R2 ack", 64'(rdData), 64'h3);
  endtask

  task automatic loPhase(input logic [29:0] hiF, input logic [29:0] loF);
    logic [63:0] expA;
    expA = {hiF, loF, 4'b0000};
    regWrite(1'b0, loF);
    chk(issueValid === 1'b1, "R3 strobe", 64'(issueValid), 64'h1);
    chk(issueAddr === expA, "R3 addr", issueAddr, expA);
    chk(rdData[1:0] == 2'b00, "R4 busy", 64'(rdData), 64'h0);
    @(negedge clk);
    chk(issueValid === 1'b0 && issueAddr === expA, "R9 pulse/hold", issueAddr, expA);
    chk(rdData[0] == 1'b0, "R4 stay low", 64'(rdData[0]), 64'h0);
    pulseDone();
    chk(complWrite === 1'b1 && rdData[0] == 1'b0, "R4 compl", {62'b0, complWrite, rdData[0]}, 64'h2);
    @(negedge clk);
    chk(complWrite === 1'b0 && rdData[0] == 1'b1, "R4 ready", {62'b0, complWrite, rdData[0]}, 64'h1);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    chk(rdData == 32'h1 && !issueValid && !complWrite, "R1 reset", 64'(rdData), 64'h1);

    // sweep of address patterns
    for (int i = 0; i < 8; i++) begin
      logic [29:0] hF, lF;
      hF = 30'h2AAAAAAA ^ (30'(i) * 30'h0123_4567);
      lF = ~hF ^ (30'(1) << (i * 3));
      hiPhase(hF);
      loPhase(hF, lF);
      chk(rdData[2] == 1'b0, "R7 no error", 64'(rdData), 64'h1);
    end

    // R8: stray completion pulse while idle
    pulseDone();
    chk(complWrite === 1'b0 && rdData == 32'h1, "R8 idle done", 64'(rdData), 64'h1);

    // R5: low write while idle
    regWrite(1'b0, 30'h1555);
    chk(issueValid === 1'b0 && rdData == 32'h5, "R5 idle low", 64'(rdData), 64'h5);
    hiPhase(30'h0F0F0F0F);
    loPhase(30'h0F0F0F0F, 30'h30303030);
    chk(rdData == 32'h5, "R7 sticky", 64'(rdData), 64'h5);

    // R7 cleared by reset only
    doReset();
    chk(rdData == 32'h1, "R1 R7 reset clears", 64'(rdData), 64'h1);

    // R6: high write inside acknowledge window
    regWrite(1'b1, 30'h11111111);
    regWrite(1'b1, 30'h22222222);
    chk(rdData == 32'h6, "R6 window", 64'(rdData), 64'h6);
    @(negedge clk);
    chk(rdData[0] == 1'b1, "R6 ack timing", 64'(rdData), 64'h7);
    loPhase(30'h11111111, 30'h3333);

    // R5: low write before acknowledge
    doReset();
    regWrite(1'b1, 30'h3C3C3C3C);
    regWrite(1'b0, 30'h1);
    chk(issueValid === 1'b0 && rdData[2] == 1'b1, "R5 early low", 64'(rdData), 64'h6);
    @(negedge clk);
    chk(rdData == 32'h7, "R2 ack after misuse", 64'(rdData), 64'h7);
    loPhase(30'h3C3C3C3C, 30'h2);

    // R6: high write while busy
    doReset();
    hiPhase(30'h00000001);
    regWrite(1'b0, 30'h3FFFFFFF);
    regWrite(1'b1, 30'h12345678);
    chk(rdData == 32'h4 && issueAddr == {30'h1, 30'h3FFFFFFF, 4'h0}, "R6 busy", 64'(rdData), 64'h4);
    pulseDone();
    chk(complWrite === 1'b1, "R4 compl after misuse", 64'(complWrite), 64'h1);
    @(negedge clk);
    chk(rdData == 32'h5, "R6 R7 end", 64'(rdData), 64'h5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule